// File: doc/BRIEF.md
# RMII Receive Deserializer (MAC side)

This block takes the two-bit receive stream of a Reduced Media Independent Interface, as seen from the MAC, and turns it into a byte stream. Every signal is sampled on one continuous 50 MHz reference clock. Once carrier-sense/data-valid goes high, the block drops the zero di-bits the PHY sends before decoding settles. It then looks for a run of preamble di-bits followed by the start-of-frame di-bit, and from the di-bit after that it assembles bytes with the least-significant pair first.

Each finished byte is delivered with a one-clock valid strobe. The first byte of a frame carries a start-of-frame flag. When carrier drops, the block emits an end-of-frame pulse. That pulse carries an alignment-error flag if the frame ended partway through a byte, and a receive-error flag if the PHY signalled an error at any point during the frame. At 10 Mb/s the PHY holds each di-bit for ten reference clocks, so the block takes one sample per ten clocks, with the phase set by the rise of carrier. In half duplex, the block raises a collision flag whenever the local transmitter is busy while carrier is present.

Top module: `rmii_rx_deser`

## Requirements
- R1: While reset is asserted and on the first clock after it is released, byteValid, sof, eof, alignErr, rxErr and collision are all 0.
- R2: After crsDv rises, di-bits of value 2'b00 that come before the preamble are discarded and never appear in any output byte.
- R3: A run of one or more preamble di-bits 2'b01 followed by the di-bit 2'b11 marks frame start. The next di-bit goes into byte bits [1:0], the one after that into [3:2], then [5:4] and [7:6].
- R4: At 100 Mb/s (speed10=0), byteValid is a one-clock pulse. It is visible one clock after the edge that samples the fourth di-bit of a byte, with byteData holding that byte. sof is high with the first byte of a frame and with no other byte.
- R5: While crsDv is low, any rxd value (including non-zero values) is ignored. It neither starts a frame nor produces a byte.
- R6: eof is a one-clock pulse, visible one clock after the first edge that samples crsDv low after frame start. If carrier drops before the start-of-frame di-bit, no eof is produced.
- R7: If crsDv drops while 1 to 3 di-bits of a byte have been taken, that partial byte is not delivered and alignErr is 1 together with eof. Otherwise alignErr is 0 at eof.
- R8: If rxEr is high on any clock from the start-of-frame di-bit until carrier drops, rxErr is 1 together with that frame's eof. The flag is cleared when the next frame starts, so a clean following frame reports rxErr=0.
- R9: collision equals halfDuplex AND txActive AND crsDv sampled at the previous clock edge. In full duplex (halfDuplex=0), collision stays 0.
- R10: At 10 Mb/s (speed10=1), a di-bit is sampled on the first clock where crsDv is high and then on every tenth clock after that. Frames assemble to the same bytes as at 100 Mb/s.
- R11: byteValid and eof are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| speed10 | input | 1 | 1 selects 10 Mb/s, 0 selects 100 Mb/s; change only while idle |
| halfDuplex | input | 1 | 1 when the link runs half duplex |
| txActive | input | 1 | Local transmitter busy |
| crsDv | input | 1 | Carrier sense / receive data valid from the PHY |
| rxd | input | 2 | Receive di-bit |
| rxEr | input | 1 | Receive error from the PHY |
| byteData | output | 8 | Assembled byte |
| byteValid | output | 1 | One-clock strobe for byteData |
| sof | output | 1 | First byte of a frame |
| eof | output | 1 | Frame closed |
| alignErr | output | 1 | Frame ended mid-byte (with eof) |
| rxErr | output | 1 | PHY error seen during frame (with eof) |
| collision | output | 1 | Half-duplex collision |

## Verification
The bound checker checks, on every cycle, the rules that tie flags to strobes. These are: sof only with a byte, alignErr and rxErr only with eof, bytes and eof never together, and no byte or eof while carrier is absent or present respectively. It also checks the one-clock collision relation, and that bytes are at least two clocks apart at 10 Mb/s. Only the bench scenarios can show that byte values and their count are right. The same goes for the zero di-bits and out-of-band idle values being discarded, the phase of the 10 Mb/s sampling, and the sticky error being cleared at the next frame. All of these depend on a whole di-bit sequence, not on a single cycle.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HUNT,
    ST_PRE,
    ST_DATA
  } rxState_t;

  typedef struct packed {
    logic takeDibit;   // a data di-bit is sampled this clock
    logic frameStart;  // start-of-frame di-bit seen
    logic frameEnd;    // carrier dropped inside a frame
    logic inFrame;     // control is in data state
  } rxCtrl_t;

  localparam logic [1:0] DIBIT_ZERO = 2'b00;
  localparam logic [1:0] DIBIT_PRE  = 2'b01;
  localparam logic [1:0] DIBIT_SFD  = 2'b11;

endpackage

// File: rtl/rmii_rx_ctrl.sv
module rmii_rx_ctrl
  import rmii_rx_pkg::*;
#(
  parameter int SLOW_DIV = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       speed10,
  input  logic       crsDv,
  input  logic [1:0] rxd,
  output rxCtrl_t    ctrl
);

  localparam int DIV_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLOW_DIV - 1);

  rxState_t state, nextState;
  logic [DIV_W-1:0] divCnt;
  logic sampleEn;

  // 10 Mb/s phase: restart when carrier is absent, so the first high clock samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (!crsDv || !speed10) begin
      divCnt <= '0;
    end else if (divCnt == DIV_LAST) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign sampleEn = !speed10 || (divCnt == '0);

  always_comb begin
    nextState = state;
    ctrl      = '0;
    ctrl.inFrame = (state == ST_DATA);
    if (!crsDv) begin
      nextState     = ST_IDLE;
      ctrl.frameEnd = (state == ST_DATA);
    end else if (sampleEn) begin
      unique case (state)
        ST_IDLE, ST_HUNT: begin
          nextState = (rxd == DIBIT_PRE) ? ST_PRE : ST_HUNT;
        end
        ST_PRE: begin
          if (rxd == DIBIT_SFD) begin
            nextState       = ST_DATA;
            ctrl.frameStart = 1'b1;
          end else if (rxd != DIBIT_PRE) begin
            nextState = ST_HUNT;
          end
        end
        ST_DATA: begin
          ctrl.takeDibit = 1'b1;
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

endmodule

// File: rtl/rmii_rx_dp.sv
module rmii_rx_dp
  import rmii_rx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxCtrl_t           ctrl,
  input  logic [1:0]        rxd,
  input  logic              rxEr,
  input  logic              crsDv,
  input  logic              halfDuplex,
  input  logic              txActive,
  output logic [BYTE_W-1:0] byteData,
  output logic              byteValid,
  output logic              sof,
  output logic              eof,
  output logic              alignErr,
  output logic              rxErr,
  output logic              collision
);

  localparam int DIBITS = BYTE_W / 2;
  localparam int CNT_W  = (DIBITS > 1) ? $clog2(DIBITS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIBITS - 1);

  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] assembled;
  logic [CNT_W-1:0]  dibitCnt;
  logic              firstPend;
  logic              errSticky;

  // newest di-bit enters at the top, so the first one ends in bits [1:0]
  assign assembled = {rxd, shiftReg[BYTE_W-1:2]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      byteData  <= '0;
      dibitCnt  <= '0;
      firstPend <= 1'b0;
      byteValid <= 1'b0;
      sof       <= 1'b0;
      eof       <= 1'b0;
      alignErr  <= 1'b0;
      rxErr     <= 1'b0;
    end else begin
      byteValid <= 1'b0;
      sof       <= 1'b0;
      eof       <= 1'b0;
      alignErr  <= 1'b0;
      rxErr     <= 1'b0;
      if (ctrl.frameStart) begin
        dibitCnt  <= '0;
        firstPend <= 1'b1;
      end else if (ctrl.takeDibit) begin
        shiftReg <= assembled;
        if (dibitCnt == CNT_LAST) begin
          byteData  <= assembled;
          byteValid <= 1'b1;
          sof       <= firstPend;
          firstPend <= 1'b0;
          dibitCnt  <= '0;
        end else begin
          dibitCnt <= dibitCnt + 1'b1;
        end
      end else if (ctrl.frameEnd) begin
        eof      <= 1'b1;
        alignErr <= (dibitCnt != '0);
        rxErr    <= errSticky;
        dibitCnt <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errSticky <= 1'b0;
    end else if (ctrl.frameStart) begin
      errSticky <= rxEr;
    end else if (ctrl.inFrame && crsDv && rxEr) begin
      errSticky <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) collision <= 1'b0;
    else       collision <= halfDuplex && txActive && crsDv;
  end

endmodule

// File: rtl/rmii_rx_deser.sv
module rmii_rx_deser
  import rmii_rx_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int SLOW_DIV = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              speed10,
  input  logic              halfDuplex,
  input  logic              txActive,
  input  logic              crsDv,
  input  logic [1:0]        rxd,
  input  logic              rxEr,
  output logic [BYTE_W-1:0] byteData,
  output logic              byteValid,
  output logic              sof,
  output logic              eof,
  output logic              alignErr,
  output logic              rxErr,
  output logic              collision
);

  rxCtrl_t ctrl;

  rmii_rx_ctrl #(.SLOW_DIV(SLOW_DIV)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .speed10 (speed10),
    .crsDv   (crsDv),
    .rxd     (rxd),
    .ctrl    (ctrl)
  );

  rmii_rx_dp #(.BYTE_W(BYTE_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .rxd        (rxd),
    .rxEr       (rxEr),
    .crsDv      (crsDv),
    .halfDuplex (halfDuplex),
    .txActive   (txActive),
    .byteData   (byteData),
    .byteValid  (byteValid),
    .sof        (sof),
    .eof        (eof),
    .alignErr   (alignErr),
    .rxErr      (rxErr),
    .collision  (collision)
  );

endmodule

// File: rtl/rmii_rx_deser_chk.sv
module rmii_rx_deser_chk (
  input logic clk,
  input logic rstN,
  input logic speed10,
  input logic halfDuplex,
  input logic txActive,
  input logic crsDv,
  input logic byteValid,
  input logic sof,
  input logic eof,
  input logic alignErr,
  input logic rxErr,
  input logic collision
);

  AST_SOF_WITH_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    sof |-> byteValid); // R4

  AST_ALIGN_AT_EOF: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |-> eof); // R7

  AST_ERR_AT_EOF: assert property (@(posedge clk) disable iff (!rstN)
    rxErr |-> eof); // R8

  AST_BYTE_EOF_APART: assert property (@(posedge clk) disable iff (!rstN)
    !(byteValid && eof)); // R11

  AST_IDLE_NO_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    !crsDv |=> !byteValid); // R5

  AST_CARRIER_NO_EOF: assert property (@(posedge clk) disable iff (!rstN)
    crsDv |=> !eof); // R6

  AST_COLL_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    (halfDuplex && txActive && crsDv) |=> collision); // R9

  AST_COLL_FULL_DUPLEX: assert property (@(posedge clk) disable iff (!rstN)
    !halfDuplex |=> !collision); // R9

  AST_SLOW_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (speed10 && byteValid) |=> !byteValid); // R10

endmodule

bind rmii_rx_deser rmii_rx_deser_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .speed10    (speed10),
  .halfDuplex (halfDuplex),
  .txActive   (txActive),
  .crsDv      (crsDv),
  .byteValid  (byteValid),
  .sof        (sof),
  .eof        (eof),
  .alignErr   (alignErr),
  .rxErr      (rxErr),
  .collision  (collision)
);

// File: tb/rmii_rx_deser_tb.sv
module rmii_rx_deser_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       speed10 = 1'b0;
  logic       halfDuplex = 1'b0;
  logic       txActive = 1'b0;
  logic       crsDv = 1'b0;
  logic [1:0] rxd = 2'b00;
  logic       rxEr = 1'b0;
  logic [7:0] byteData;
  logic       byteValid, sof, eof, alignErr, rxErr, collision;

  always #2 clk = ~clk;

  rmii_rx_deser u_dut (
    .clk(clk), .rstN(rstN), .speed10(speed10), .halfDuplex(halfDuplex),
    .txActive(txActive), .crsDv(crsDv), .rxd(rxd), .rxEr(rxEr),
    .byteData(byteData), .byteValid(byteValid), .sof(sof), .eof(eof),
    .alignErr(alignErr), .rxErr(rxErr), .collision(collision)
  );

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor, sampled away from the active edge
  logic [7:0] monBytes [16];
  logic       monSof   [16];
  int monCnt = 0, sofCnt = 0, eofCnt = 0, overlap = 0;
  logic lastAlign = 1'b0, lastErr = 1'b0;

  always @(negedge clk) begin
    if (byteValid) begin
      if (monCnt < 16) begin
        monBytes[monCnt] = byteData;
        monSof[monCnt]   = sof;
      end
      monCnt++;
    end
    if (sof) sofCnt++;
    if (eof) begin
      eofCnt++;
      lastAlign = alignErr;
      lastErr   = rxErr;
    end
    if (byteValid && eof) overlap++;
  end

  task automatic clearMon();
    monCnt = 0; sofCnt = 0; eofCnt = 0; lastAlign = 1'b0; lastErr = 1'b0;
  endtask

  function automatic logic [7:0] expByte(input logic [7:0] seed, input int i);
    return 8'(seed + 8'(i * 37));
  endfunction

  task automatic sendDibit(input logic [1:0] d, input logic e, input int hold);
    crsDv = 1'b1; rxd = d; rxEr = e;
    repeat (hold) @(negedge clk);
  endtask

  task automatic dropCarrier();
    crsDv = 1'b0; rxd = 2'b00; rxEr = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic sendFrame(input bit spd, input int lead, input int pre, input int nb,
                           input logic [7:0] seed, input int part, input int errAt);
    int hold;
    logic [7:0] b;
    speed10 = spd;
    @(negedge clk);
    hold = spd ? 10 : 1;
    for (int i = 0; i < lead; i++) sendDibit(2'b00, 1'b0, hold);
    for (int i = 0; i < pre; i++)  sendDibit(2'b01, 1'b0, hold);
    sendDibit(2'b11, 1'b0, hold);
    for (int i = 0; i < nb; i++) begin
      b = expByte(seed, i);
      for (int k = 0; k < 4; k++) sendDibit(b[2*k +: 2], (errAt == i*4 + k), hold);
    end
    for (int i = 0; i < part; i++) sendDibit(2'b10, 1'b0, hold);
    dropCarrier();
  endtask

  typedef struct packed {
    logic       spd;
    logic [3:0] lead;
    logic [3:0] pre;
    logic [3:0] nb;
    logic [7:0] seed;
    logic [1:0] part;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{1'b0, 4'd3, 4'd7, 4'd4, 8'h5A, 2'd0},
    '{1'b0, 4'd0, 4'd1, 4'd3, 8'hC3, 2'd0},
    '{1'b0, 4'd5, 4'd3, 4'd2, 8'h0F, 2'd1},
    '{1'b0, 4'd1, 4'd7, 4'd1, 8'hFF, 2'd3},
    '{1'b1, 4'd2, 4'd3, 4'd2, 8'h96, 2'd0},
    '{1'b1, 4'd0, 4'd2, 4'd1, 8'h3C, 2'd2}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check({byteValid, sof, eof, alignErr, rxErr, collision} == 6'b0, "R1 in reset",
          int'({byteValid, sof, eof, alignErr, rxErr, collision}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check({byteValid, sof, eof, alignErr, rxErr, collision} == 6'b0, "R1 after release",
          int'({byteValid, sof, eof, alignErr, rxErr, collision}), 0);

    // table of frames: R2 leading zeros, R3 assembly, R4 sof, R6 eof, R7 alignment, R10 slow rate
    foreach (VECS[v]) begin
      clearMon();
      sendFrame(VECS[v].spd, int'(VECS[v].lead), int'(VECS[v].pre), int'(VECS[v].nb),
                VECS[v].seed, int'(VECS[v].part), -1);
      check(monCnt == int'(VECS[v].nb), VECS[v].spd ? "R10 byte count" : "R2 byte count",
            monCnt, int'(VECS[v].nb));
      for (int i = 0; i < int'(VECS[v].nb); i++)
        check(monBytes[i] == expByte(VECS[v].seed, i), VECS[v].spd ? "R10 byte value" : "R3 byte value",
              int'(monBytes[i]), int'(expByte(VECS[v].seed, i)));
      check(sofCnt == 1 && monSof[0] == 1'b1, "R4 sof on first byte only", sofCnt, 1);
      check(eofCnt == 1, "R6 one eof", eofCnt, 1);
      check(lastAlign == (VECS[v].part != 0), "R7 alignErr", int'(lastAlign),
            int'(VECS[v].part != 0));
      check(lastErr == 1'b0, "R8 no error", int'(lastErr), 0);
    end

    // R4 exact timing at 100 Mb/s
    clearMon();
    speed10 = 1'b0;
    sendDibit(2'b01, 1'b0, 1);
    sendDibit(2'b11, 1'b0, 1);
    sendDibit(2'b10, 1'b0, 1);
    sendDibit(2'b01, 1'b0, 1);
    sendDibit(2'b11, 1'b0, 1);
    check(byteValid == 1'b0, "R4 no strobe before 4th dibit", int'(byteValid), 0);
    sendDibit(2'b00, 1'b0, 1);
    check(byteValid == 1'b1 && sof == 1'b1, "R4 strobe one clock after 4th dibit",
          int'({byteValid, sof}), 3);
    check(byteData == 8'h36, "R3 lsb dibit first", int'(byteData), 'h36);
    sendDibit(2'b01, 1'b0, 1);
    check(byteValid == 1'b0, "R4 strobe lasts one clock", int'(byteValid), 0);
    crsDv = 1'b0; rxd = 2'b00;
    @(negedge clk);
    check(eof == 1'b1 && alignErr == 1'b1, "R6 R7 eof one clock after drop",
          int'({eof, alignErr}), 3);
    @(negedge clk);
    check(eof == 1'b0, "R6 eof lasts one clock", int'(eof), 0);
    repeat (3) @(negedge clk);

    // R5 out-of-band idle values ignored, including an SFD-like pattern
    clearMon();
    crsDv = 1'b0;
    rxd = 2'b01; @(negedge clk);
    rxd = 2'b01; @(negedge clk);
    rxd = 2'b11; @(negedge clk);
    rxd = 2'b10; @(negedge clk);
    for (int i = 0; i < 4; i++) sendDibit(2'b10, 1'b0, 1);
    dropCarrier();
    check(monCnt == 0 && eofCnt == 0, "R5 idle values ignored", monCnt + eofCnt, 0);

    // R6 drop before start-of-frame gives no eof
    clearMon();
    sendDibit(2'b00, 1'b0, 1);
    sendDibit(2'b01, 1'b0, 1);
    sendDibit(2'b01, 1'b0, 1);
    dropCarrier();
    check(eofCnt == 0, "R6 no eof before sfd", eofCnt, 0);

    // R8 sticky error and its clearing
    clearMon();
    sendFrame(1'b0, 1, 4, 2, 8'h11, 0, 5);
    check(lastErr == 1'b1 && eofCnt == 1, "R8 error reported at eof", int'(lastErr), 1);
    check(monCnt == 2, "R8 bytes still delivered", monCnt, 2);
    clearMon();
    sendFrame(1'b0, 0, 2, 1, 8'h22, 0, -1);
    check(lastErr == 1'b0, "R8 cleared at next frame", int'(lastErr), 0);
    clearMon();
    sendFrame(1'b1, 0, 2, 1, 8'h44, 0, 2);
    check(lastErr == 1'b1, "R8 error at 10M", int'(lastErr), 1);

    // R9 collision
    speed10 = 1'b0;
    halfDuplex = 1'b1; txActive = 1'b1; crsDv = 1'b0;
    @(negedge clk);
    check(collision == 1'b0, "R9 no carrier no collision", int'(collision), 0);
    crsDv = 1'b1;
    @(negedge clk);
    check(collision == 1'b1, "R9 collision half duplex", int'(collision), 1);
    halfDuplex = 1'b0;
    @(negedge clk);
    check(collision == 1'b0, "R9 full duplex no collision", int'(collision), 0);
    halfDuplex = 1'b1; txActive = 1'b0;
    @(negedge clk);
    check(collision == 1'b0, "R9 tx idle no collision", int'(collision), 0);
    dropCarrier();

    check(overlap == 0, "R11 byte and eof apart", overlap, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule